// File: doc/BRIEF.md
# SDRAM command decoder and checker

This block watches the control pins of a two-bank synchronous DRAM on every rising clock edge. It turns the pin pattern into a one-hot command code and reports the bank the command addressed. It keeps its own record of which banks are activated and of the one read or write access in flight. From that record it flags commands that are not allowed in the current state. It also follows the clock-enable pin, so it knows which edges a command may execute on and when the clock is suspended.

All outputs are registered. A command sampled on edge n appears on `cmdCode`, `cmdBank` and `err` after edge n, and its effect on `bankOpen` shows after that same edge. `err` is high for one cycle per offending edge. An illegal command is still reported on `cmdCode`, but it changes no state. Burst length is a static setting. The block counts the data cycles of each access so it knows when the access ends and when a pending auto-deactivate takes effect.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `csN` low, the pins {`rasN`,`casN`,`weN`} decode as follows. 000 is mode set (cmdCode bit 2). 001 is refresh (bit 3). 011 is activate (bit 4). 010 with `autoDeac` low is deactivate one bank (bit 5), and with `autoDeac` high is deactivate all (bit 6). 100 is write (bit 7, or bit 8 when `autoDeac` is high). 101 is read (bit 9, or bit 10 when `autoDeac` is high). 110 is burst stop (bit 11). 111 is no-op (bit 0). With `csN` high the code is deselect (bit 1), whatever the other pins are. cmdCode never has more than one bit set.
- R2: `bankSel` high addresses bank T and low addresses bank B. `bankOpen[1]` is bank T and `bankOpen[0]` is bank B. `cmdBank` reports `bankSel` of each executed command.
- R3: Activate is legal only when the addressed bank is deactivated, and it sets that bank's `bankOpen` bit. Otherwise `err` pulses and the state is unchanged.
- R4: Read, write and burst stop are legal only when the addressed bank is activated. Otherwise `err` pulses and the state is unchanged.
- R5: Deactivate one bank clears the addressed bank. Deactivate all clears both banks. Both are legal in any bank state.
- R6: Mode set and refresh are legal only when both banks are deactivated. Mode set also needs `modeBits` equal to 00. A violation pulses `err`.
- R7: A command on edge n executes only if `cke` was high at edge n-1. Otherwise `cmdCode` is 0 after edge n and bank state is untouched.
- R8: After each edge, `hold` equals the inverse of the `cke` value sampled at that edge. A suspended edge is one that follows an edge with `cke` low.
- R9: With burst length BL = 2^`burstLen`, an access issued on edge n ends at edge n+BL for a read and at edge n+BL+1 for a write. An auto-deactivate access clears its bank at that edge.
- R10: Suspended edges do not advance the access count, so each one delays the end of the access by one edge.
- R11: The edge after the last data-in cycle of a write is edge n+BL. A `cke` fall on that edge pulses `err`.
- R12: Burst stop ends the current access at once, and a pending auto-deactivate then takes effect on that edge. A read or write issued while an auto-deactivate access is in progress is illegal.
- R13: A synchronous active-high `rst` leaves both banks deactivated, `hold` low, `err` low and `cmdCode` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| bankSel | input | 1 | Bank address bit (1 = T, 0 = B) |
| autoDeac | input | 1 | Auto-deactivate / all-banks address bit |
| modeBits | input | 2 | Address bits that must be zero on mode set |
| burstLen | input | 2 | Burst length code, BL = 2^burstLen |
| cmdCode | output | 12 | One-hot decoded command |
| cmdBank | output | 1 | Bank of the last executed command |
| bankOpen | output | 2 | Per-bank activated flags |
| hold | output | 1 | Clock suspend on the next edge |
| err | output | 1 | One-cycle illegal-command pulse |

## Verification
The properties assume that every input is a known value at each edge and that `burstLen` does not change while an access is in progress. They also assume `rst` is held high from time zero for at least one edge. The bench changes `burstLen` only right after a reset, drives every input to a defined level before the first edge, and changes inputs two nanoseconds after a rising edge. Each directed sequence starts from reset, so the bank and access state that the properties compare against is always known.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;
  localparam int NUM_CMD = 12;
  localparam int C_NOOP  = 0;
  localparam int C_DESL  = 1;
  localparam int C_MRS   = 2;
  localparam int C_REFR  = 3;
  localparam int C_ACTV  = 4;
  localparam int C_DEAC  = 5;
  localparam int C_DCAB  = 6;
  localparam int C_WRT   = 7;
  localparam int C_WRTP  = 8;
  localparam int C_READ  = 9;
  localparam int C_READP = 10;
  localparam int C_STOP  = 11;
  localparam int NUM_BANKS = 2;

  typedef struct packed {
    logic                 advance;
    logic                 startAcc;
    logic                 accWrite;
    logic                 accAuto;
    logic                 accBank;
    logic                 stopAcc;
    logic [NUM_BANKS-1:0] openMask;
    logic [NUM_BANKS-1:0] closeMask;
  } dpStrobe_t;
endpackage

// File: rtl/sdmon_dp.sv
module sdmon_dp
  import sdmon_pkg::*;
#(
  parameter int MAX_BL_LOG = 3,
  parameter int BL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpStrobe_t            strobe,
  input  logic [BL_W-1:0]      burstLen,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 autoBusy,
  output logic                 writeTail
);
  localparam int MAX_CNT = (1 << MAX_BL_LOG) + 1;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0]     accCnt;
  logic                 accWr;
  logic                 apPend;
  logic                 apBank;
  logic [CNT_W-1:0]     burstCycles;
  logic                 endNow;
  logic [NUM_BANKS-1:0] nextOpen;

  assign burstCycles = CNT_W'(1) << burstLen;
  assign endNow = (strobe.advance && accCnt == CNT_W'(1)) ||
                  (strobe.stopAcc && accCnt != '0);

  always_comb begin
    nextOpen = bankOpen;
    if (endNow && apPend) nextOpen[apBank] = 1'b0;
    nextOpen = (nextOpen & ~strobe.closeMask) | strobe.openMask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bankOpen <= '0;
      accCnt   <= '0;
      accWr    <= 1'b0;
      apPend   <= 1'b0;
      apBank   <= 1'b0;
    end else begin
      bankOpen <= nextOpen;
      if (strobe.startAcc) begin
        accCnt <= burstCycles + CNT_W'(strobe.accWrite);
        accWr  <= strobe.accWrite;
        apPend <= strobe.accAuto;
        apBank <= strobe.accBank;
      end else begin
        if (strobe.stopAcc) accCnt <= '0;
        else if (strobe.advance && accCnt != '0) accCnt <= accCnt - CNT_W'(1);
        if (endNow || strobe.closeMask[apBank]) apPend <= 1'b0;
      end
    end
  end

  assign autoBusy  = apPend;
  assign writeTail = accWr && accCnt == CNT_W'(2);
endmodule

// File: rtl/sdmon_ctrl.sv
module sdmon_ctrl
  import sdmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic                 bankSel,
  input  logic                 autoDeac,
  input  logic [1:0]           modeBits,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 autoBusy,
  input  logic                 writeTail,
  output dpStrobe_t            strobe,
  output logic [NUM_CMD-1:0]   cmdCode,
  output logic                 cmdBank,
  output logic                 hold,
  output logic                 err
);
  logic                 ckePrev;
  logic [NUM_CMD-1:0]   dec;
  logic                 legal;
  logic                 fire;
  logic                 selOpen;
  logic                 isRw;
  logic                 isStop;
  logic [NUM_BANKS-1:0] openReq;
  logic [NUM_BANKS-1:0] closeReq;
  logic                 suspendErr;

  assign selOpen = bankOpen[bankSel];

  always_comb begin
    dec      = '0;
    legal    = 1'b1;
    isRw     = 1'b0;
    isStop   = 1'b0;
    openReq  = '0;
    closeReq = '0;
    if (csN) begin
      dec[C_DESL] = 1'b1;
    end else begin
      case ({rasN, casN, weN})
        3'b000: begin
          dec[C_MRS] = 1'b1;
          legal = (bankOpen == '0) && (modeBits == 2'b00);
        end
        3'b001: begin
          dec[C_REFR] = 1'b1;
          legal = (bankOpen == '0);
        end
        3'b010: begin
          if (autoDeac) begin
            dec[C_DCAB] = 1'b1;
            closeReq    = '1;
          end else begin
            dec[C_DEAC]       = 1'b1;
            closeReq[bankSel] = 1'b1;
          end
        end
        3'b011: begin
          dec[C_ACTV]      = 1'b1;
          legal            = !selOpen;
          openReq[bankSel] = 1'b1;
        end
        3'b100: begin
          dec[autoDeac ? C_WRTP : C_WRT] = 1'b1;
          legal = selOpen && !autoBusy;
          isRw  = 1'b1;
        end
        3'b101: begin
          dec[autoDeac ? C_READP : C_READ] = 1'b1;
          legal = selOpen && !autoBusy;
          isRw  = 1'b1;
        end
        3'b110: begin
          dec[C_STOP] = 1'b1;
          legal  = selOpen;
          isStop = 1'b1;
        end
        default: dec[C_NOOP] = 1'b1;
      endcase
    end
  end

  assign fire       = ckePrev && legal;
  assign suspendErr = ckePrev && !cke && writeTail;

  always_comb begin
    strobe.advance   = ckePrev;
    strobe.startAcc  = fire && isRw;
    strobe.accWrite  = !weN;
    strobe.accAuto   = autoDeac;
    strobe.accBank   = bankSel;
    strobe.stopAcc   = fire && isStop;
    strobe.openMask  = fire ? openReq : '0;
    strobe.closeMask = fire ? closeReq : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ckePrev <= 1'b1;
      cmdCode <= '0;
      cmdBank <= 1'b0;
      err     <= 1'b0;
    end else begin
      ckePrev <= cke;
      cmdCode <= ckePrev ? dec : '0;
      if (ckePrev) cmdBank <= bankSel;
      err     <= (ckePrev && !legal) || suspendErr;
    end
  end

  assign hold = !ckePrev;
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int MAX_BL_LOG = 3,
  localparam int BL_W = $clog2(MAX_BL_LOG + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic                 bankSel,
  input  logic                 autoDeac,
  input  logic [1:0]           modeBits,
  input  logic [BL_W-1:0]      burstLen,
  output logic [NUM_CMD-1:0]   cmdCode,
  output logic                 cmdBank,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 hold,
  output logic                 err
);
  dpStrobe_t strobe;
  logic      autoBusy;
  logic      writeTail;

  sdmon_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .autoDeac(autoDeac), .modeBits(modeBits),
    .bankOpen(bankOpen), .autoBusy(autoBusy), .writeTail(writeTail),
    .strobe(strobe), .cmdCode(cmdCode), .cmdBank(cmdBank), .hold(hold), .err(err)
  );

  sdmon_dp #(.MAX_BL_LOG(MAX_BL_LOG), .BL_W(BL_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .burstLen(burstLen),
    .bankOpen(bankOpen), .autoBusy(autoBusy), .writeTail(writeTail)
  );
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdmon_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 bankSel,
  input logic [NUM_CMD-1:0]   cmdCode,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 hold,
  input logic                 err
);
  a_r1_onehot_code: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmdCode));

  a_r8_hold_tracks_cke: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (hold == !$past(cke)));

  a_r7_no_exec_suspended: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(hold)) |-> (cmdCode == '0));

  a_r3_open_only_by_activate: assert property (@(posedge clk) disable iff (rst)
    ((bankOpen & ~$past(bankOpen)) != '0) |-> (cmdCode[C_ACTV] && !err));

  a_r6_mode_refresh_idle: assert property (@(posedge clk) disable iff (rst)
    ((cmdCode[C_MRS] || cmdCode[C_REFR]) && !err) |-> ($past(bankOpen) == '0));

  a_r4_access_needs_open: assert property (@(posedge clk) disable iff (rst)
    ((cmdCode[C_WRT] || cmdCode[C_WRTP] || cmdCode[C_READ] || cmdCode[C_READP] ||
      cmdCode[C_STOP]) && !err) |-> $past(bankOpen[bankSel]));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk i_chk (.*);

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic        cke = 1'b1, bankSel = 1'b0, autoDeac = 1'b0;
  logic [1:0]  modeBits = 2'b00;
  logic [1:0]  burstLen = 2'd0;
  logic [11:0] cmdCode;
  logic        cmdBank;
  logic [1:0]  bankOpen;
  logic        hold;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst(rst), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .autoDeac(autoDeac), .modeBits(modeBits),
    .burstLen(burstLen), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .bankOpen(bankOpen), .hold(hold), .err(err)
  );

  typedef struct packed {
    logic       cs, ras, cas, we, ba, a10;
    logic [1:0] mb;
    logic [11:0] code;
    logic [1:0] open;
    logic       e;
  } vec_t;

  localparam vec_t VEC [19] = '{
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,12'h001,2'b00,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,12'h002,2'b00,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,12'h004,2'b00,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,12'h004,2'b00,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,12'h008,2'b00,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,12'h010,2'b10,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,12'h010,2'b10,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,12'h004,2'b10,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,12'h008,2'b10,1'b1},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,12'h200,2'b10,1'b1},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,12'h010,2'b11,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,12'h080,2'b11,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,12'h001,2'b11,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,12'h001,2'b11,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,12'h800,2'b11,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,12'h020,2'b01,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,12'h800,2'b01,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b00,12'h040,2'b00,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,12'h020,2'b00,1'b0}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic r, input logic ca, input logic w,
                      input logic b, input logic a, input logic k);
    csN = c; rasN = r; casN = ca; weN = w; bankSel = b; autoDeac = a; cke = k;
    @(posedge clk); #2;
  endtask

  task automatic nop(input logic k);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, k);
  endtask

  task automatic doReset(input logic [1:0] bl);
    rst = 1'b1; burstLen = bl; modeBits = 2'b00;
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1; cke = 1'b1;
    bankSel = 1'b0; autoDeac = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R13 reset state
    doReset(2'd0);
    chk("R13", "cmdCode", 32'(cmdCode), 32'h0);
    chk("R13", "bankOpen", 32'(bankOpen), 32'h0);
    chk("R13", "hold", 32'(hold), 32'h0);
    chk("R13", "err", 32'(err), 32'h0);

    // R1..R6 table walk, burst length 1
    foreach (VEC[i]) begin
      modeBits = VEC[i].mb;
      step(VEC[i].cs, VEC[i].ras, VEC[i].cas, VEC[i].we, VEC[i].ba, VEC[i].a10, 1'b1);
      chk("R1", "cmdCode", 32'(cmdCode), 32'(VEC[i].code));
      chk("R2", "cmdBank", 32'(cmdBank), 32'(VEC[i].ba));
      chk("R3/R4/R5", "bankOpen", 32'(bankOpen), 32'(VEC[i].open));
      chk("R4/R6", "err", 32'(err), 32'(VEC[i].e));
    end
    modeBits = 2'b00;

    // R7 R8 suspend: commands ignored while suspended
    doReset(2'd0);
    nop(1'b0);
    chk("R8", "hold after cke fall", 32'(hold), 32'h1);
    chk("R7", "cmd before suspend", 32'(cmdCode), 32'h001);
    chk("R11", "no err without write", 32'(err), 32'h0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7", "suspended cmdCode", 32'(cmdCode), 32'h0);
    chk("R7", "suspended activate ignored", 32'(bankOpen), 32'h0);
    nop(1'b1);
    chk("R8", "hold after cke rise", 32'(hold), 32'h0);
    chk("R7", "last suspended edge", 32'(cmdCode), 32'h0);
    nop(1'b1);
    chk("R7", "execution resumed", 32'(cmdCode), 32'h001);

    // R9 read with auto-deactivate, BL=4
    doReset(2'd2);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9", "read-ap code", 32'(cmdCode), 32'h400);
    for (int k = 1; k <= 3; k++) begin
      nop(1'b1);
      chk("R9", "read bank still open", 32'(bankOpen), 32'h2);
    end
    nop(1'b1);
    chk("R9", "read bank closed at n+BL", 32'(bankOpen), 32'h0);

    // R9 write with auto-deactivate, BL=2
    doReset(2'd1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9", "write-ap code", 32'(cmdCode), 32'h100);
    nop(1'b1);
    nop(1'b1);
    chk("R9", "write bank open at n+BL", 32'(bankOpen), 32'h1);
    nop(1'b1);
    chk("R9", "write bank closed at n+BL+1", 32'(bankOpen), 32'h0);

    // R10 suspend freezes the access count
    doReset(2'd0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R10", "hold with read", 32'(hold), 32'h1);
    nop(1'b1);
    chk("R10", "frozen edge keeps bank", 32'(bankOpen), 32'h2);
    nop(1'b1);
    chk("R10", "bank closed one edge late", 32'(bankOpen), 32'h0);

    // R11 cke fall right after last write data-in, BL=2
    doReset(2'd1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R11", "write legal", 32'(err), 32'h0);
    nop(1'b1);
    chk("R11", "last data-in no err", 32'(err), 32'h0);
    nop(1'b0);
    chk("R11", "cke fall after write", 32'(err), 32'h1);
    nop(1'b1);
    chk("R11", "err is a pulse", 32'(err), 32'h0);

    // R12 busy auto-deactivate access and burst stop, BL=8
    doReset(2'd3);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R12", "read during auto access", 32'(err), 32'h1);
    chk("R12", "bank still open", 32'(bankOpen), 32'h2);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R12", "stop code", 32'(cmdCode), 32'h800);
    chk("R12", "stop legal", 32'(err), 32'h0);
    chk("R12", "stop applies auto-deactivate", 32'(bankOpen), 32'h0);

    // R13 reset clears mid-run state
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    nop(1'b0);
    doReset(2'd0);
    chk("R13", "bankOpen after reset", 32'(bankOpen), 32'h0);
    chk("R13", "hold after reset", 32'(hold), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule